// File: doc/BRIEF.md
# Bidirectional Rotating-Ring Word Indexer

This block routes a set of N input words onto M output words according to a programmable selection map. Each of the M map cells holds a code: a value from 1 to N picks that input word, and 0 picks a blank (all-zero) word. Inputs may therefore be repeated, dropped or reordered, and blanks may be placed anywhere in the output.

The N inputs, plus a permanent blank word, sit in a circular ring of N+1 registers. Each register carries a tag that records its original slot. For each map cell in turn, the ring turns one slot per cycle towards the requested word, in whichever direction is shorter around the ring. When the register at the head of the ring has the requested tag, its word is copied into the output file. The output file and the map then advance together by one cell. After M copies the output file holds the result in map order, and the map is back in its original arrangement.

The ring is not returned to a home position between cells or between operations, so the cost of each cell depends on where the previous cell left the ring. Software loads the inputs and the map while the block is idle, pulses start, and waits for the one-cycle done pulse.

Top module: `ring_index_router`

## Requirements
- R1: A map code of 0, or any code above N (7 with the defaults), produces an all-zero word in that output cell.
- R2: A map code k in 1..N places input word k in that output cell; one input may feed several cells, and inputs that no cell names do not appear.
- R3: When done pulses, output cell i (bits [i*W +: W] of out_words) holds the word that map cell i selects. The map is unchanged by an operation, so running again gives the same result.
- R4: For each cell the ring turns by the shorter way around: the forward distance is d = (q - p) mod (N+1), where p is the current head tag and q the target. The ring turns forward when 2*d <= N+1 and backward otherwise. Each cell costs min(d, N+1-d) turns plus one copy cycle. The head position carries over from cell to cell and from one operation to the next.
- R5: A start pulse accepted while idle raises busy from the next cycle. Busy stays high for exactly the total cycle cost of R4. Done is high for exactly one cycle, the first cycle after busy falls.
- R6: While busy, input loads, map writes and start pulses have no effect on that operation or on later results.
- R7: After synchronous reset, busy and done are low, out_words is zero, every map cell is 0, every input word is zero, and the head position is 0.
- R8: An input load whose index is 0 or above N is ignored, so the blank word stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_wr | input | 1 | Write one input word (ignored while busy) |
| in_sel | input | CW=3 | Input index to write, 1..N |
| in_data | input | W=8 | Input word value |
| map_wr | input | 1 | Write one map cell (ignored while busy) |
| map_sel | input | MW=2 | Map cell index, 0..M-1 |
| map_code | input | CW=3 | Selection code for that cell |
| start | input | 1 | Begin an operation (accepted only when idle) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| out_words | output | M*W=32 | Output cell i at bits [i*W +: W] |

## Verification
The map is driven with a table of patterns. These include an in-order copy, a full reversal, one input repeated into every cell, a mix of blank codes with out-of-range codes, and alternating targets at opposite sides of the ring. Together they separate correct word selection from errors in direction choice and wrap-around. A head position that is not carried over between cells shows up as a wrong cycle count, even when the data is right. Directed cases inject loads, map writes and start pulses mid-operation, try to overwrite the blank slot, and rerun the same map to confirm that the map returns to its original arrangement.

// File: rtl/rir_pkg.sv
package rir_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rir_state_t;
endpackage

// File: rtl/rir_ring.sv
module rir_ring #(
  parameter int N  = 6,
  parameter int W  = 8,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [CW-1:0] ld_sel,
  input  logic [W-1:0]  ld_data,
  input  logic          rot_fwd,
  input  logic          rot_bwd,
  output logic [W-1:0]  head_data,
  output logic [CW-1:0] head_tag
);
  localparam int S = N + 1;
  localparam logic [CW-1:0] NC = CW'(N);

  logic [W-1:0]  slot_dat [S];
  logic [CW-1:0] slot_tag [S];
  logic          sel_ok;

  assign sel_ok = (ld_sel != '0) && (ld_sel <= NC);

  for (genvar j = 0; j < S; j++) begin : g_slot
    localparam int NXT = (j + 1) % S;
    localparam int PRV = (j + S - 1) % S;
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_dat[j] <= '0;
        slot_tag[j] <= CW'(j);
      end else if (rot_fwd) begin
        slot_dat[j] <= slot_dat[NXT];
        slot_tag[j] <= slot_tag[NXT];
      end else if (rot_bwd) begin
        slot_dat[j] <= slot_dat[PRV];
        slot_tag[j] <= slot_tag[PRV];
      end else if (ld_en && sel_ok && (slot_tag[j] == ld_sel)) begin
        slot_dat[j] <= ld_data;
      end
    end
  end

  assign head_data = slot_dat[0];
  assign head_tag  = slot_tag[0];
endmodule

// File: rtl/rir_outq.sv
module rir_outq #(
  parameter int M  = 4,
  parameter int W  = 8,
  parameter int CW = 3,
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          map_we,
  input  logic [MW-1:0] map_sel,
  input  logic [CW-1:0] map_code,
  input  logic          shift_en,
  input  logic [W-1:0]  shift_in,
  output logic [CW-1:0] cur_code,
  output logic [M*W-1:0] out_flat
);
  logic [CW-1:0] map_q [M];
  logic [W-1:0]  res_q [M];

  for (genvar i = 0; i < M; i++) begin : g_cell
    localparam int NXT = (i + 1) % M;
    always_ff @(posedge clk) begin
      if (rst) begin
        map_q[i] <= '0;
        res_q[i] <= '0;
      end else if (shift_en) begin
        map_q[i] <= map_q[NXT];
        res_q[i] <= (i == M - 1) ? shift_in : res_q[NXT];
      end else if (map_we && (map_sel == MW'(i))) begin
        map_q[i] <= map_code;
      end
    end
    assign out_flat[i*W +: W] = res_q[i];
  end

  assign cur_code = map_q[0];
endmodule

// File: rtl/rir_ctrl.sv
module rir_ctrl
  import rir_pkg::*;
#(
  parameter int N  = 6,
  parameter int M  = 4,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] cur_code,
  input  logic [CW-1:0] head_tag,
  output logic          rot_fwd,
  output logic          rot_bwd,
  output logic          xfer,
  output logic          busy,
  output logic          done
);
  localparam int S  = N + 1;
  localparam int KW = $clog2(M + 1);
  localparam logic [CW-1:0] NC = CW'(N);
  localparam logic [CW:0]   SC = (CW + 1)'(S);

  rir_state_t    state;
  logic [KW-1:0] cnt;
  logic [CW-1:0] tgt;
  logic [CW:0]   fdist;
  logic [CW+1:0] fdist2;
  logic          run;

  assign run = (state == ST_RUN);
  assign tgt = (cur_code > NC) ? '0 : cur_code;

  always_comb begin
    if (tgt >= head_tag) fdist = {1'b0, tgt} - {1'b0, head_tag};
    else                 fdist = {1'b0, tgt} + SC - {1'b0, head_tag};
    fdist2 = {fdist, 1'b0};
  end

  assign xfer    = run && (tgt == head_tag);
  assign rot_fwd = run && !xfer && (fdist2 <= {1'b0, SC});
  assign rot_bwd = run && !xfer && !(fdist2 <= {1'b0, SC});
  assign busy    = run;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (start) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
      end else if (xfer) begin
        if (cnt == KW'(M - 1)) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ring_index_router.sv
module ring_index_router #(
  parameter int N  = 6,
  parameter int M  = 4,
  parameter int W  = 8,
  parameter int CW = $clog2(N + 1),
  parameter int MW = (M > 1) ? $clog2(M) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_wr,
  input  logic [CW-1:0]  in_sel,
  input  logic [W-1:0]   in_data,
  input  logic           map_wr,
  input  logic [MW-1:0]  map_sel,
  input  logic [CW-1:0]  map_code,
  input  logic           start,
  output logic           busy,
  output logic           done,
  output logic [M*W-1:0] out_words
);
  logic [W-1:0]  head_data;
  logic [CW-1:0] head_tag;
  logic [CW-1:0] cur_code;
  logic          rot_fwd, rot_bwd, xfer;

  rir_ring #(.N(N), .W(W), .CW(CW)) u_ring (
    .clk(clk), .rst(rst),
    .ld_en(in_wr && !busy), .ld_sel(in_sel), .ld_data(in_data),
    .rot_fwd(rot_fwd), .rot_bwd(rot_bwd),
    .head_data(head_data), .head_tag(head_tag)
  );

  rir_outq #(.M(M), .W(W), .CW(CW), .MW(MW)) u_outq (
    .clk(clk), .rst(rst),
    .map_we(map_wr && !busy), .map_sel(map_sel), .map_code(map_code),
    .shift_en(xfer), .shift_in(head_data),
    .cur_code(cur_code), .out_flat(out_words)
  );

  rir_ctrl #(.N(N), .M(M), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .cur_code(cur_code), .head_tag(head_tag),
    .rot_fwd(rot_fwd), .rot_bwd(rot_bwd), .xfer(xfer),
    .busy(busy), .done(done)
  );
endmodule

// File: rtl/rir_checker.sv
module rir_checker #(
  parameter int N  = 6,
  parameter int M  = 4,
  parameter int W  = 8,
  parameter int CW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic           done,
  input logic           rot_fwd,
  input logic           rot_bwd,
  input logic           xfer,
  input logic [CW-1:0]  head_tag,
  input logic [W-1:0]   head_data,
  input logic [M*W-1:0] out_words
);
  localparam logic [CW-1:0] NC = CW'(N);

  // R4: one ring action per cycle at most
  p_single_action_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rot_fwd, rot_bwd, xfer}));

  // R4: a forward turn advances the head tag by one, wrapping after N
  p_fwd_step_r4: assert property (@(posedge clk) disable iff (rst)
    rot_fwd |=> head_tag == (($past(head_tag) == NC) ? '0 : $past(head_tag) + 1'b1));

  // R4: a backward turn retreats the head tag by one, wrapping below 0
  p_bwd_step_r4: assert property (@(posedge clk) disable iff (rst)
    rot_bwd |=> head_tag == (($past(head_tag) == '0) ? NC : $past(head_tag) - 1'b1));

  // R1: the blank slot always holds zero
  p_blank_head_r1: assert property (@(posedge clk) disable iff (rst)
    (head_tag == '0) |-> (head_data == '0));

  // R6: nothing moves while idle
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(rot_fwd || rot_bwd || xfer));

  // R6: output file changes only on a copy
  p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> $stable(out_words));

  // R5: done is a single-cycle pulse following a copy
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_xfer_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(xfer) && !busy));
endmodule

bind ring_index_router rir_checker #(.N(N), .M(M), .W(W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .rot_fwd(rot_fwd), .rot_bwd(rot_bwd), .xfer(xfer),
  .head_tag(head_tag), .head_data(head_data), .out_words(out_words)
);

// File: tb/ring_index_router_bench.sv
module ring_index_router_bench;
  localparam int N = 6, M = 4, W = 8, CW = 3, MW = 2;
  localparam int NV = 6;
  // map patterns, cell 3 in the top bits down to cell 0 in the low bits
  localparam logic [11:0] VEC [NV] = '{
    {3'd4, 3'd3, 3'd2, 3'd1},
    {3'd1, 3'd2, 3'd3, 3'd4},
    {3'd5, 3'd5, 3'd5, 3'd5},
    {3'd1, 3'd0, 3'd7, 3'd6},
    {3'd1, 3'd6, 3'd1, 3'd6},
    {3'd2, 3'd0, 3'd3, 3'd5}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst = 1'b1;
  logic           in_wr = 1'b0, map_wr = 1'b0, start = 1'b0;
  logic [CW-1:0]  in_sel = '0, map_code = '0;
  logic [W-1:0]   in_data = '0;
  logic [MW-1:0]  map_sel = '0;
  logic           busy, done;
  logic [M*W-1:0] out_words;

  ring_index_router #(.N(N), .M(M), .W(W)) u_ring_index_router (
    .clk(clk), .rst(rst), .in_wr(in_wr), .in_sel(in_sel), .in_data(in_data),
    .map_wr(map_wr), .map_sel(map_sel), .map_code(map_code), .start(start),
    .busy(busy), .done(done), .out_words(out_words)
  );

  int checks = 0, fails = 0;
  int mpos = 0;
  logic [CW-1:0] mmap [M];
  logic [W-1:0]  mword [N+1];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    mpos = 0;
    for (int c = 0; c < M; c++) mmap[c] = '0;
    for (int k = 0; k <= N; k++) mword[k] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
  endtask

  task automatic load_input(input int k, input logic [W-1:0] v);
    @(negedge clk); in_wr = 1'b1; in_sel = CW'(k); in_data = v;
    @(negedge clk); in_wr = 1'b0;
    if (k >= 1 && k <= N) mword[k] = v;
  endtask

  task automatic set_map(input logic [11:0] v);
    for (int c = 0; c < M; c++) begin
      @(negedge clk); map_wr = 1'b1; map_sel = MW'(c); map_code = v[c*CW +: CW];
      mmap[c] = v[c*CW +: CW];
    end
    @(negedge clk); map_wr = 1'b0;
  endtask

  task automatic model_run(output logic [M*W-1:0] eo, output int ecyc);
    int q, d;
    ecyc = 0;
    for (int c = 0; c < M; c++) begin
      q = int'(mmap[c]);
      if (q > N) q = 0;
      d = (q - mpos + N + 1) % (N + 1);
      ecyc += ((2 * d <= N + 1) ? d : (N + 1 - d)) + 1;
      mpos = q;
      eo[c*W +: W] = (q == 0) ? '0 : mword[q];
    end
  endtask

  task automatic run_op(input bit poke, input string req);
    logic [M*W-1:0] eo;
    int ecyc, cyc, guard;
    model_run(eo, ecyc);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R5", "busy after start", busy, 1);
    cyc = 0; guard = 0;
    while (!done && guard < 1000) begin
      if (busy) cyc++;
      if (poke && busy && cyc == 2) begin
        map_wr = 1'b1; map_sel = '0; map_code = 3'd3;
        in_wr = 1'b1; in_sel = 3'd2; in_data = 8'hEE;
        start = 1'b1;
      end else begin
        map_wr = 1'b0; in_wr = 1'b0; start = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    map_wr = 1'b0; in_wr = 1'b0; start = 1'b0;
    chk(done == 1'b1, "R5", "done seen", done, 1);
    chk(busy == 1'b0, "R5", "busy low with done", busy, 0);
    chk(out_words == eo, req, "output words", out_words, eo);
    chk(cyc == ecyc, "R4", "busy cycles", cyc, ecyc);
    @(negedge clk);
    chk(done == 1'b0, "R5", "done one cycle", done, 0);
    chk(busy == 1'b0, "R6", "no restart after poked start", busy, 0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R7: reset state
    chk(busy == 1'b0, "R7", "busy after reset", busy, 0);
    chk(done == 1'b0, "R7", "done after reset", done, 0);
    chk(out_words == '0, "R7", "outputs after reset", out_words, 0);
    run_op(1'b0, "R7");                  // reset map all blank, 4 cycles

    // R8: writes to index 0 and to an index above N are dropped
    load_input(0, 8'hFF);
    load_input(7, 8'hFF);
    run_op(1'b0, "R8");

    for (int k = 1; k <= N; k++) load_input(k, W'(8'h11 * k));

    // R2 R3 R4 R1: table of map patterns
    for (int v = 0; v < NV; v++) begin
      set_map(VEC[v]);
      run_op(1'b0, (v == 3) ? "R1" : "R2");
    end

    // R6: loads, map writes and start during busy are ignored
    set_map({3'd1, 3'd6, 3'd2, 3'd6});
    run_op(1'b1, "R6");
    // R3: map kept its arrangement, same result again
    run_op(1'b0, "R3");

    // R7: reset again clears words, map and head position
    do_reset();
    chk(out_words == '0, "R7", "outputs after second reset", out_words, 0);
    run_op(1'b0, "R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule